// File: doc/BRIEF.md
# Power-Gated Pin Function Multiplexer

This block sits between one bidirectional pad and the on-chip logic that may use it. A small control register picks which of several functions owns the pad. Function 0 is the plain GPIO. The register also sets the drive direction, the push-pull or open-drain style, the pull resistor and the power-well mode. The chosen function's data and drive request are steered to the pad. Every function's receive line gets either the pad value or a fixed per-function idle level.

The pin can behave as if it were supplied from a switchable rail. The block takes a power-good level from the system and passes it through a two-stage synchronizer. When the pin is in emulated-well mode and that level is low, the pad driver is released and the receive lines of gated functions fall back to their idle levels. An always-on mode removes this dependence. Functions marked ungated always see the pad. A pin built with a single function keeps function 0 whatever the select field holds.

Top module: `pgmux_pin`

## Requirements
- R1: The control word's select field, bits [MUX_W-1:0] (bits [1:0] by default), chooses the function. While the pad is driven in push-pull style, `pad_out` equals `func_out[select]`.
- R2: After reset the control word holds RESET_CFG (default 7'h10). This is function 0, input direction, push-pull, pull-up, emulated-well mode. In that state `pad_oe` is 0, `pull_up` is 1 and `pull_dn` is 0.
- R3: In emulated-well mode (bit MUX_W+4 = 0), `pad_oe` is 0 whenever the synchronized power-good is low. When it is high, the pad drives normally.
- R4: A gated function's `func_in[i]` equals GATE_VAL[i] whenever the well is off or function i is not selected. It equals `pad_in` when the well is on and function i is selected.
- R5: A function whose NO_GATE bit is set has `func_in[i]` equal to `pad_in` at all times.
- R6: In always-on mode (bit MUX_W+4 = 1), power-good is ignored. The pad drives, and the selected function receives the pad, even while power-good is low.
- R7: In open-drain style (bit MUX_W+1 = 1), a data value of 0 drives the pad low with `pad_oe` = 1. A data value of 1 releases the pad with `pad_oe` = 0.
- R8: The pad is driven only when the direction bit (bit MUX_W, 1 = output) is set and the selected function's `func_oe` is 1.
- R9: The pull field, bits [MUX_W+3:MUX_W+2], sets the pulls as follows: 01 raises `pull_up`, 10 raises `pull_dn`, and 00 or 11 raises neither. The two pulls are never high together.
- R10: With SINGLE_FUNC set, function 0 owns the pad regardless of the select field. Power gating still applies.
- R11: A change on `pwr_good` takes effect on the outputs after exactly two rising clock edges.
- R12: A write on `cfg_wr` takes effect from the next rising edge. In that same cycle, every function that is no longer selected receives its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | CTRL_W | Control word to write |
| pwr_good | input | 1 | Emulated-rail power-good, asynchronous |
| pad_in | input | 1 | Value sensed at the pad |
| func_out | input | NUM_FUNC | Data each function wants to drive |
| func_oe | input | NUM_FUNC | Drive request of each function |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| pull_up | output | 1 | Pull-up enable |
| pull_dn | output | 1 | Pull-down enable |
| func_in | output | NUM_FUNC | Gated receive value per function |

## Verification
On every cycle, the assertions check four things: the driver is released while the emulated well is down, open-drain never drives high, the two pulls are exclusive, and every unselected gated function holds its idle level while ungated ones track the pad. They also tie each edge of the synchronized power-good to the raw level two cycles earlier. Only the bench's scenarios show three further things: the reset value of the control word, the exact cycle in which a write or a power-good change reaches the pad, and the data steering for each select value. The same scenarios cover always-on override and the single-function build.

// File: rtl/pgmux_pkg.sv
package pgmux_pkg;

  typedef enum logic [1:0] {
    PULL_OFF   = 2'b00,
    PULL_HIGH  = 2'b01,
    PULL_LOW   = 2'b10,
    PULL_OFF_B = 2'b11
  } pull_e;

  // {up, down} lines for a pull code
  function automatic logic [1:0] pull_lines(pull_e code);
    case (code)
      PULL_HIGH: return 2'b10;
      PULL_LOW:  return 2'b01;
      default:   return 2'b00;
    endcase
  endfunction

  // driver enable: needs live well, a drive request, and in open-drain only a zero
  function automatic logic drive_enable(logic well, logic req, logic od, logic val);
    return well & req & (~od | ~val);
  endfunction

  // value presented to the driver
  function automatic logic drive_value(logic od, logic val);
    return od ? 1'b0 : val;
  endfunction

endpackage

// File: rtl/pgmux_sync.sv
module pgmux_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgmux_cfg_reg.sv
module pgmux_cfg_reg #(
  parameter int          WIDTH     = 7,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/pgmux_in_gate.sv
module pgmux_in_gate #(
  parameter int                 NUM_FUNC = 4,
  parameter int                 MUX_W    = 2,
  parameter logic [NUM_FUNC-1:0] GATE_VAL = '0,
  parameter logic [NUM_FUNC-1:0] NO_GATE  = '0
) (
  input  logic                pad_in,
  input  logic                well_on,
  input  logic [MUX_W-1:0]    sel,
  output logic [NUM_FUNC-1:0] func_in
);
  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
    if (NO_GATE[i]) begin : g_open
      assign func_in[i] = pad_in;
    end else begin : g_gated
      logic live;
      assign live       = well_on && (sel == MUX_W'(i));
      assign func_in[i] = live ? pad_in : GATE_VAL[i];
    end
  end
endmodule

// File: rtl/pgmux_out_stage.sv
module pgmux_out_stage
  import pgmux_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int MUX_W    = 2
) (
  input  logic [NUM_FUNC-1:0] func_out,
  input  logic [NUM_FUNC-1:0] func_oe,
  input  logic [MUX_W-1:0]    sel,
  input  logic                dir_out,
  input  logic                open_drain,
  input  pull_e               pull,
  input  logic                well_on,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                pull_up,
  output logic                pull_dn
);
  logic       data_sel;
  logic       req_sel;
  logic [1:0] pulls;

  always_comb begin
    data_sel = 1'b0;
    req_sel  = 1'b0;
    for (int i = 0; i < NUM_FUNC; i++) begin
      if (sel == MUX_W'(i)) begin
        data_sel = func_out[i];
        req_sel  = func_oe[i];
      end
    end
  end

  assign pad_out = drive_value(open_drain, data_sel);
  assign pad_oe  = drive_enable(well_on, dir_out & req_sel, open_drain, data_sel);
  assign pulls   = pull_lines(pull);
  assign pull_up = pulls[1];
  assign pull_dn = pulls[0];
endmodule

// File: rtl/pgmux_pin.sv
module pgmux_pin
  import pgmux_pkg::*;
#(
  parameter int                  NUM_FUNC    = 4,
  parameter logic [NUM_FUNC-1:0] GATE_VAL    = 4'b1010,
  parameter logic [NUM_FUNC-1:0] NO_GATE     = 4'b0100,
  parameter bit                  SINGLE_FUNC = 1'b0,
  parameter int                  SYNC_STAGES = 2,
  localparam int                 MUX_W       = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1,
  localparam int                 CTRL_W      = MUX_W + 5,
  parameter logic [CTRL_W-1:0]   RESET_CFG   = CTRL_W'(7'h10)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CTRL_W-1:0]   cfg_wdata,
  input  logic                pwr_good,
  input  logic                pad_in,
  input  logic [NUM_FUNC-1:0] func_out,
  input  logic [NUM_FUNC-1:0] func_oe,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                pull_up,
  output logic                pull_dn,
  output logic [NUM_FUNC-1:0] func_in
);
  localparam int DIR_BIT = MUX_W;
  localparam int OD_BIT  = MUX_W + 1;
  localparam int PULL_LO = MUX_W + 2;
  localparam int AON_BIT = MUX_W + 4;

  logic [CTRL_W-1:0] cfg_q;
  logic              pg_sync;
  logic              well_on;
  logic [MUX_W-1:0]  sel_eff;

  pgmux_cfg_reg #(.WIDTH(CTRL_W), .RESET_VAL(RESET_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .q(cfg_q)
  );

  pgmux_sync #(.STAGES(SYNC_STAGES)) u_pg (
    .clk(clk), .rst_n(rst_n), .d(pwr_good), .q(pg_sync)
  );

  // always-on pins ignore the rail; emulated pins follow synchronized power-good
  assign well_on = cfg_q[AON_BIT] | pg_sync;

  // a single-function pin pins the select to function 0
  if (SINGLE_FUNC) begin : g_single
    assign sel_eff = '0;
  end else begin : g_multi
    assign sel_eff = cfg_q[MUX_W-1:0];
  end

  pgmux_out_stage #(.NUM_FUNC(NUM_FUNC), .MUX_W(MUX_W)) u_out (
    .func_out(func_out), .func_oe(func_oe), .sel(sel_eff),
    .dir_out(cfg_q[DIR_BIT]), .open_drain(cfg_q[OD_BIT]),
    .pull(pull_e'(cfg_q[PULL_LO+1:PULL_LO])), .well_on(well_on),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  pgmux_in_gate #(.NUM_FUNC(NUM_FUNC), .MUX_W(MUX_W),
                  .GATE_VAL(GATE_VAL), .NO_GATE(NO_GATE)) u_in (
    .pad_in(pad_in), .well_on(well_on), .sel(sel_eff), .func_in(func_in)
  );
endmodule

// File: rtl/pgmux_pin_chk.sv
module pgmux_pin_chk #(
  parameter int                  NUM_FUNC = 4,
  parameter int                  MUX_W    = 2,
  parameter int                  CTRL_W   = 7,
  parameter logic [NUM_FUNC-1:0] GATE_VAL = '0,
  parameter logic [NUM_FUNC-1:0] NO_GATE  = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_good,
  input logic                pg_sync,
  input logic [CTRL_W-1:0]   cfg_q,
  input logic [MUX_W-1:0]    sel_eff,
  input logic                pad_in,
  input logic                pad_out,
  input logic                pad_oe,
  input logic                pull_up,
  input logic                pull_dn,
  input logic [NUM_FUNC-1:0] func_in
);
  a_r3_float_when_well_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[MUX_W+4] && !pg_sync) |-> !pad_oe);

  a_r7_open_drain_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[MUX_W+1] && pad_oe) |-> !pad_out);

  a_r9_pulls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pull_up, pull_dn}));

  a_r11_pg_rise_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_sync) |-> $past(pwr_good, 2));

  a_r11_pg_fall_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_sync) |-> !$past(pwr_good, 2));

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
    if (NO_GATE[i]) begin : g_open
      a_r5_ungated_follows_pad: assert property (@(posedge clk) disable iff (!rst_n)
        func_in[i] == pad_in);
    end else begin : g_gated
      a_r4_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_eff != MUX_W'(i)) |-> (func_in[i] == GATE_VAL[i]));
    end
  end
endmodule

bind pgmux_pin pgmux_pin_chk #(
  .NUM_FUNC(NUM_FUNC), .MUX_W(MUX_W), .CTRL_W(CTRL_W),
  .GATE_VAL(GATE_VAL), .NO_GATE(NO_GATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pg_sync(pg_sync),
  .cfg_q(cfg_q), .sel_eff(sel_eff), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn), .func_in(func_in)
);

// File: tb/pgmux_pin_test.sv
module pgmux_pin_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       pwr_good = 1'b0;
  logic       pad_in = 1'b0;
  logic [3:0] func_out = '0;
  logic [3:0] func_oe = '0;
  logic       pad_out, pad_oe, pull_up, pull_dn;
  logic [3:0] func_in;
  logic       s_pad_out, s_pad_oe, s_pull_up, s_pull_dn;
  logic [3:0] s_func_in;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  pgmux_pin uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pwr_good(pwr_good), .pad_in(pad_in), .func_out(func_out), .func_oe(func_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
    .func_in(func_in)
  );

  pgmux_pin #(.SINGLE_FUNC(1'b1)) uut_single (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pwr_good(pwr_good), .pad_in(pad_in), .func_out(func_out), .func_oe(func_oe),
    .pad_out(s_pad_out), .pad_oe(s_pad_oe), .pull_up(s_pull_up), .pull_dn(s_pull_dn),
    .func_in(s_func_in)
  );

  // control word: {always_on, pull[1:0], open_drain, dir_out, select[1:0]}
  function automatic logic [6:0] cw(bit aon, bit [1:0] pull, bit od, bit dir, bit [1:0] sel);
    return {aon, pull, od, dir, sel};
  endfunction

  // idle levels: functions 1 and 3 idle high, function 2 ungated
  function automatic logic [3:0] exp_in(int sel, bit well, bit pad);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      if (i == 2)                  r[i] = pad;
      else if (well && i == sel)   r[i] = pad;
      else                         r[i] = (i == 1 || i == 3);
    end
    return r;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [6:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  task automatic set_pg(bit v);
    @(negedge clk);
    pwr_good = v;
    @(negedge clk); @(negedge clk); #1;
  endtask

  task automatic t_reset;
    #1;
    check("R2 oe at reset", pad_oe, 0);
    check("R2 pull_up at reset", pull_up, 1);
    check("R2 pull_dn at reset", pull_dn, 0);
    pad_in = 1'b1; #1;
    check("R4 gated inputs at reset pad=1", func_in, exp_in(0, 0, 1));
    pad_in = 1'b0; #1;
    check("R5 ungated input at reset pad=0", func_in, exp_in(0, 0, 0));
  endtask

  task automatic t_power;
    func_out = 4'b0001; func_oe = 4'b1111;
    write_cfg(cw(0, 2'b00, 0, 1, 2'd0));
    check("R3 well down no drive", pad_oe, 0);
    @(negedge clk); pwr_good = 1'b1;
    @(negedge clk); #1;
    check("R11 one edge not yet", pad_oe, 0);
    @(negedge clk); #1;
    check("R11 two edges drives", pad_oe, 1);
    check("R3 data when well up", pad_out, 1);
    set_pg(0);
    check("R3 released after power loss", pad_oe, 0);
    set_pg(1);
  endtask

  task automatic t_mux;
    func_out = 4'b0101; func_oe = 4'b1111;
    for (int s = 0; s < 4; s++) begin
      write_cfg(cw(0, 2'b00, 0, 1, 2'(s)));
      check("R1 pad data for select", pad_out, func_out[s]);
      check("R12 new select same cycle", func_in, exp_in(s, 1, pad_in));
      pad_in = ~pad_in; #1;
      check("R4 selected follows pad", func_in, exp_in(s, 1, pad_in));
    end
  endtask

  task automatic t_dir;
    func_out = 4'b1111; func_oe = 4'b1111;
    write_cfg(cw(0, 2'b00, 0, 0, 2'd1));
    check("R8 input direction", pad_oe, 0);
    write_cfg(cw(0, 2'b00, 0, 1, 2'd1));
    func_oe = 4'b1101; #1;
    check("R8 function not requesting", pad_oe, 0);
    func_oe = 4'b1111; #1;
    check("R8 function requesting", pad_oe, 1);
  endtask

  task automatic t_od;
    func_oe = 4'b1111;
    write_cfg(cw(0, 2'b00, 1, 1, 2'd3));
    func_out = 4'b1000; #1;
    check("R7 od release on one", pad_oe, 0);
    func_out = 4'b0000; #1;
    check("R7 od drives on zero", {pad_oe, pad_out}, 2'b10);
  endtask

  task automatic t_pull;
    logic [1:0] exp_p [4] = '{2'b00, 2'b10, 2'b01, 2'b00};
    for (int p = 0; p < 4; p++) begin
      write_cfg(cw(0, 2'(p), 0, 0, 2'd0));
      check("R9 pull decode", {pull_up, pull_dn}, exp_p[p]);
    end
  endtask

  task automatic t_aon;
    set_pg(0);
    func_out = 4'b0001; func_oe = 4'b1111;
    write_cfg(cw(1, 2'b00, 0, 1, 2'd0));
    check("R6 always-on drives w/o power", pad_oe, 1);
    pad_in = 1'b1; #1;
    check("R6 always-on input live", func_in, exp_in(0, 1, 1));
    write_cfg(cw(0, 2'b00, 0, 1, 2'd0));
    check("R6 emulated again floats", pad_oe, 0);
  endtask

  task automatic t_single;
    set_pg(1);
    func_out = 4'b0110; func_oe = 4'b1111; pad_in = 1'b1;
    write_cfg(cw(0, 2'b00, 0, 1, 2'd2));
    check("R10 single pad data", s_pad_out, 0);
    check("R10 single inputs", s_func_in, exp_in(0, 1, 1));
    set_pg(0);
    check("R10 single still gated", {s_pad_oe, s_func_in}, {1'b0, exp_in(0, 0, 1)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R2 control after release", {pad_oe, pull_up, pull_dn}, 3'b010);
    t_power;
    t_mux;
    t_dir;
    t_od;
    t_pull;
    t_aon;
    t_single;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule